// File: doc/BRIEF.md
# Operand Offset Resolver with Shift Penalty

This execute-side stage takes micro-ops after register read. Each of its two source operands arrives as a raw register value, a signed 11-bit displacement and a "folded" marker. The stage adds each displacement, sign-extended, to its value to form the true operand. It then evaluates the micro-op in a small ALU and shifter, and returns the result with the micro-op's tag on a one-cycle result strobe.

Folding a displacement costs nothing for arithmetic and logic classes, which finish one clock edge after acceptance. Shift and rotate classes are different: if either operand carries a displacement or is marked folded, they take three clock edges. A plain shift with both displacements zero and both markers clear still finishes in one. Fast and slow micro-ops may be in flight at the same time. The input is held off for one cycle only when a fast micro-op would reach the result register on the same edge as an earlier slow one.

The result register is a small state machine with three states. `SRC_NONE` means no result this cycle. `SRC_FAST` holds a result from the one-cycle path. `SRC_SLOW` holds a result drained from the delay pipeline. Every edge chooses the next state:
- to `SRC_SLOW` whenever the last pipeline stage is occupied;
- otherwise to `SRC_FAST` when a fast micro-op is accepted;
- otherwise to `SRC_NONE`.

Top module: `opnd_offset_resolver`

## Requirements
- R1: Each effective operand equals its register value plus its displacement taken as an 11-bit two's complement number sign-extended to 64 bits, with modulo-2^64 wraparound.
- R2: Opcodes 0 to 5 (0 add a+b, 1 subtract a-b, 2 and, 3 or, 4 xor, 5 pass a) produce out_valid exactly one clock edge after acceptance, whatever the displacements and fold markers are.
- R3: Opcodes 6 to 15 are shift and rotate classes. When either operand has a nonzero displacement or a set fold marker, they produce out_valid exactly three clock edges after acceptance.
- R4: Opcodes 6 to 15 with both displacements zero and both fold markers clear produce out_valid one clock edge after acceptance.
- R5: For opcodes 6 to 15 the shift count is bits [5:0] of the effective b operand, taken after the displacement has been added.
- R6: The shift and rotate results are as follows. 6 and 13 shift left logical. 7 and 14 shift right logical. 8 and 15 shift right arithmetic. 9 rotates left and 10 rotates right. 11 and 12 rotate left and right through the 65-bit value {in_carry, a}, returning the low 64 bits.
- R7: One micro-op is accepted per cycle while in_ready is high. in_ready is low exactly when a slow result completes on the next edge and the offered micro-op is not slow-class. In-flight fast and slow micro-ops complete independently.
- R8: Each result appears with the tag of its own micro-op, and out_valid is high for exactly one cycle per accepted micro-op.
- R9: While rst_n is low and after it is released, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Micro-op offered |
| in_ready | output | 1 | Micro-op accepted on this edge if in_valid |
| in_tag | input | TAG_W | Micro-op tag |
| in_op | input | 4 | Opcode class, encoding as in R2 and R6 |
| in_carry | input | 1 | Carry-in for rotates through carry |
| a_val | input | DATA_W | Operand a register value |
| a_off | input | OFF_W | Operand a signed displacement |
| a_fold | input | 1 | Operand a marked as folded |
| b_val | input | DATA_W | Operand b (count) register or immediate value |
| b_off | input | OFF_W | Operand b signed displacement |
| b_fold | input | 1 | Operand b marked as folded |
| out_valid | output | 1 | Result strobe |
| out_tag | output | TAG_W | Tag of the completing micro-op |
| out_result | output | DATA_W | Result value |

## Verification
The bench builds the block with its default parameters: 64-bit data, 11-bit displacements, 4-bit tags and a slow latency of three. With these values every one of the 2048 displacements can be swept through the adder. Every count from 0 to 63 can be applied to all ten shift and rotate opcodes, both with and without a displacement, and again with high garbage bits on the count operand. The 4-bit tag is wide enough to tell apart overlapping fast and slow micro-ops in the collision and back-to-back sequences.

// File: rtl/oor_pkg.sv
package oor_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_PASS = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_SAR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_RCL  = 4'd11,
        OP_RCR  = 4'd12,
        OP_SHLN = 4'd13,
        OP_SHRN = 4'd14,
        OP_SARN = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FAST = 2'd1,
        SRC_SLOW = 2'd2
    } out_src_e;

    function automatic logic is_shift_class(input logic [3:0] op);
        return op >= 4'd6;
    endfunction

endpackage

// File: rtl/oor_operand_fold.sv
module oor_operand_fold #(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 11
) (
    input  logic [DATA_W-1:0] val,
    input  logic [OFF_W-1:0]  off,
    input  logic              fold,
    output logic [DATA_W-1:0] eff,
    output logic              displaced
);
    localparam int EXT_W = DATA_W - OFF_W;

    always_comb begin
        eff       = val + {{EXT_W{off[OFF_W-1]}}, off};
        displaced = fold || (off != '0);
    end
endmodule

// File: rtl/oor_exec_unit.sv
module oor_exec_unit
    import oor_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] result
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int RC_W  = DATA_W + 1;

    logic [CNT_W-1:0]      cnt;
    logic [2*DATA_W-1:0]   dbl_l, dbl_r;
    logic [RC_W-1:0]       rc_word;
    logic [2*RC_W-1:0]     rc_l, rc_r;

    always_comb begin
        cnt     = b[CNT_W-1:0];
        dbl_l   = {a, a} << cnt;
        dbl_r   = {a, a} >> cnt;
        rc_word = {cin, a};
        rc_l    = {rc_word, rc_word} << cnt;
        rc_r    = {rc_word, rc_word} >> cnt;
        unique case (op_e'(op))
            OP_ADD:          result = a + b;
            OP_SUB:          result = a - b;
            OP_AND:          result = a & b;
            OP_OR:           result = a | b;
            OP_XOR:          result = a ^ b;
            OP_PASS:         result = a;
            OP_SHL, OP_SHLN: result = a << cnt;
            OP_SHR, OP_SHRN: result = a >> cnt;
            OP_SAR, OP_SARN: result = DATA_W'($signed(a) >>> cnt);
            OP_ROL:          result = dbl_l[2*DATA_W-1:DATA_W];
            OP_ROR:          result = dbl_r[DATA_W-1:0];
            OP_RCL:          result = rc_l[2*RC_W-2:RC_W];
            OP_RCR:          result = rc_r[DATA_W-1:0];
            default:         result = '0;
        endcase
    end
endmodule

// File: rtl/oor_slow_pipe.sv
module oor_slow_pipe #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [DATA_W-1:0] push_res,
    output logic              last_vld,
    output logic [TAG_W-1:0]  last_tag,
    output logic [DATA_W-1:0] last_res
);
    logic [DEPTH-1:0]  stg_vld;
    logic [TAG_W-1:0]  stg_tag [DEPTH];
    logic [DATA_W-1:0] stg_res [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_vld[0] <= 1'b0;
                    stg_tag[0] <= '0;
                    stg_res[0] <= '0;
                end else begin
                    stg_vld[0] <= push;
                    stg_tag[0] <= push_tag;
                    stg_res[0] <= push_res;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_vld[i] <= 1'b0;
                    stg_tag[i] <= '0;
                    stg_res[i] <= '0;
                end else begin
                    stg_vld[i] <= stg_vld[i-1];
                    stg_tag[i] <= stg_tag[i-1];
                    stg_res[i] <= stg_res[i-1];
                end
            end

            // R3
            stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
                stg_vld[i-1] |=> (stg_vld[i] && stg_tag[i] == $past(stg_tag[i-1])));
        end
    end

    assign last_vld = stg_vld[DEPTH-1];
    assign last_tag = stg_tag[DEPTH-1];
    assign last_res = stg_res[DEPTH-1];
endmodule

// File: rtl/opnd_offset_resolver.sv
module opnd_offset_resolver
    import oor_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int OFF_W    = 11,
    parameter int TAG_W    = 4,
    parameter int SLOW_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [3:0]        in_op,
    input  logic              in_carry,
    input  logic [DATA_W-1:0] a_val,
    input  logic [OFF_W-1:0]  a_off,
    input  logic              a_fold,
    input  logic [DATA_W-1:0] b_val,
    input  logic [OFF_W-1:0]  b_off,
    input  logic              b_fold,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_result
);
    localparam int NUM_SRC    = 2;
    localparam int PIPE_DEPTH = SLOW_LAT - 1;

    logic [DATA_W-1:0] src_val  [NUM_SRC];
    logic [OFF_W-1:0]  src_off  [NUM_SRC];
    logic              src_fold [NUM_SRC];
    logic [DATA_W-1:0] src_eff  [NUM_SRC];
    logic [NUM_SRC-1:0] src_disp;

    assign src_val[0]  = a_val;
    assign src_off[0]  = a_off;
    assign src_fold[0] = a_fold;
    assign src_val[1]  = b_val;
    assign src_off[1]  = b_off;
    assign src_fold[1] = b_fold;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        oor_operand_fold #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_fold (
            .val       (src_val[k]),
            .off       (src_off[k]),
            .fold      (src_fold[k]),
            .eff       (src_eff[k]),
            .displaced (src_disp[k])
        );
    end

    logic [DATA_W-1:0] exec_res;

    oor_exec_unit #(.DATA_W(DATA_W)) u_exec (
        .op     (in_op),
        .a      (src_eff[0]),
        .b      (src_eff[1]),
        .cin    (in_carry),
        .result (exec_res)
    );

    logic needs_slow, accept, fast_fire, slow_fire;
    logic              pipe_last_vld;
    logic [TAG_W-1:0]  pipe_last_tag;
    logic [DATA_W-1:0] pipe_last_res;

    assign needs_slow = is_shift_class(in_op) && (src_disp != '0);
    assign in_ready   = !(pipe_last_vld && !needs_slow);
    assign accept     = in_valid && in_ready;
    assign fast_fire  = accept && !needs_slow;
    assign slow_fire  = accept && needs_slow;

    oor_slow_pipe #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(PIPE_DEPTH)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (slow_fire),
        .push_tag (in_tag),
        .push_res (exec_res),
        .last_vld (pipe_last_vld),
        .last_tag (pipe_last_tag),
        .last_res (pipe_last_res)
    );

    out_src_e          src_q, src_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] res_q, res_d;

    always_comb begin
        if (pipe_last_vld) begin
            src_d = SRC_SLOW;
            tag_d = pipe_last_tag;
            res_d = pipe_last_res;
        end else if (fast_fire) begin
            src_d = SRC_FAST;
            tag_d = in_tag;
            res_d = exec_res;
        end else begin
            src_d = SRC_NONE;
            tag_d = tag_q;
            res_d = res_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= SRC_NONE;
        else        src_q <= src_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            res_q <= '0;
        end else begin
            tag_q <= tag_d;
            res_q <= res_d;
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_FAST, SRC_SLOW: out_valid = 1'b1;
            default:            out_valid = 1'b0;
        endcase
        out_tag    = tag_q;
        out_result = res_q;
    end

    // R2
    alu_single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_shift_class(in_op)) |=> (out_valid && out_tag == $past(in_tag)));

    // R4
    plain_shift_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_shift_class(in_op) && a_off == '0 && b_off == '0 && !a_fold && !b_fold)
        |=> (out_valid && out_tag == $past(in_tag)));

    // R8
    result_has_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(fast_fire || pipe_last_vld));
endmodule

// File: tb/opnd_offset_resolver_bench.sv
`timescale 1ns/1ps
module opnd_offset_resolver_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_tag = '0;
    logic [3:0]  in_op = '0;
    logic        in_carry = 1'b0;
    logic [63:0] a_val = '0, b_val = '0;
    logic [10:0] a_off = '0, b_off = '0;
    logic        a_fold = 1'b0, b_fold = 1'b0;
    logic        out_valid;
    logic [3:0]  out_tag;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] rng = 64'h2545_F491_4F6C_DD1D;
    logic [3:0]  next_tag = 4'd1;

    always #2.5 clk = ~clk;

    opnd_offset_resolver u_opnd_offset_resolver (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_op(in_op), .in_carry(in_carry),
        .a_val(a_val), .a_off(a_off), .a_fold(a_fold),
        .b_val(b_val), .b_off(b_off), .b_fold(b_fold),
        .out_valid(out_valid), .out_tag(out_tag), .out_result(out_result)
    );

    function automatic logic [63:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    function automatic logic [63:0] resolve(input logic [63:0] v, input logic [10:0] off);
        if (off[10]) return v - 64'(12'd2048 - {1'b0, off});
        return v + 64'(off);
    endfunction

    function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic cin);
        int n;
        logic [63:0] r;
        logic c, t;
        n = int'(b[5:0]);
        r = a;
        c = cin;
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a;
            4'd6, 4'd13: return a << n;
            4'd7, 4'd14: return a >> n;
            default: begin
                for (int i = 0; i < n; i++) begin
                    case (op)
                        4'd8, 4'd15: r = {r[63], r[63:1]};
                        4'd9:  r = {r[62:0], r[63]};
                        4'd10: r = {r[0], r[63:1]};
                        4'd11: begin t = r[63]; r = {r[62:0], c}; c = t; end
                        default: begin t = r[0]; r = {c, r[63:1]}; c = t; end
                    endcase
                end
                return r;
            end
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [63:0] a, input logic [10:0] ao,
                         input logic af, input logic [63:0] b, input logic [10:0] bo,
                         input logic bf, input logic cin, input logic [3:0] tag);
        in_op = op; a_val = a; a_off = ao; a_fold = af;
        b_val = b; b_off = bo; b_fold = bf; in_carry = cin; in_tag = tag;
        in_valid = 1'b1;
    endtask

    task automatic run_op(input string req, input logic [3:0] op, input logic [63:0] a,
                          input logic [10:0] ao, input logic af, input logic [63:0] b,
                          input logic [10:0] bo, input logic bf, input logic cin);
        int lat, exp_lat;
        logic [63:0] exp_res;
        logic [3:0] tag;
        tag = next_tag;
        next_tag = next_tag + 4'd1;
        exp_lat = (op >= 4'd6 && (ao != 0 || bo != 0 || af || bf)) ? 3 : 1;
        exp_res = model(op, resolve(a, ao), resolve(b, bo), cin);
        @(negedge clk);
        drive(op, a, ao, af, b, bo, bf, cin, tag);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, req, "latency", 64'(lat), 64'(exp_lat));
        check(out_tag == tag, "R8", "tag", 64'(out_tag), 64'(tag));
        check(out_result == exp_res, req, "result", out_result, exp_res);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] x, y;
        repeat (3) @(negedge clk);
        // R9 during reset
        check(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 0);
        check(in_ready == 1'b1, "R9", "in_ready in reset", 64'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 0);
        check(in_ready == 1'b1, "R9", "in_ready after reset", 64'(in_ready), 1);

        // R1: every displacement through the adder and pass path
        for (int i = -1024; i < 1024; i++) begin
            x = rnd();
            run_op("R1", 4'd0, x, 11'(i), 1'b0, 64'd0, 11'd0, 1'b0, 1'b0);
        end
        run_op("R1", 4'd5, 64'd0, 11'h400, 1'b0, 64'd0, 11'd0, 1'b0, 1'b0);
        run_op("R1", 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 11'd1, 1'b0, 64'd0, 11'd0, 1'b0, 1'b0);

        // R2: arithmetic and logic classes with displacements and fold markers
        for (int op = 0; op < 6; op++) begin
            for (int j = 0; j < 8; j++) begin
                x = rnd(); y = rnd();
                run_op("R2", 4'(op), x, 11'(rnd()), j[0], y, 11'(rnd()), j[1], 1'b0);
            end
        end

        // R4, R5, R6: plain shifts every count; R3, R5, R6: displaced count
        for (int op = 6; op < 16; op++) begin
            for (int n = 0; n < 64; n++) begin
                x = rnd();
                run_op("R6", 4'(op), x, 11'd0, 1'b0, 64'(n), 11'd0, 1'b0, x[7]);
                run_op("R3", 4'(op), x, 11'd0, 1'b0, 64'(n) + 64'd5, 11'h7FB, 1'b0, x[9]);
                run_op("R5", 4'(op), x, 11'd0, 1'b0, {58'h2A5, 6'(n)}, 11'd0, 1'b0, x[3]);
            end
            // R3: displaced value operand, fold marker with zero displacement
            run_op("R3", 4'(op), rnd(), 11'd3, 1'b0, 64'd4, 11'd0, 1'b0, 1'b1);
            run_op("R3", 4'(op), rnd(), 11'd0, 1'b1, 64'd9, 11'd0, 1'b0, 1'b0);
            run_op("R3", 4'(op), rnd(), 11'd0, 1'b0, 64'd9, 11'd0, 1'b1, 1'b1);
            run_op("R4", 4'(op), rnd(), 11'd0, 1'b0, 64'd17, 11'd0, 1'b0, 1'b0);
        end
        // R5: displacement carries into the count field
        run_op("R5", 4'd6, 64'd1, 11'd0, 1'b0, 64'd63, 11'd2, 1'b0, 1'b0);

        // R7: fast after slow collides and stalls one cycle
        @(negedge clk);
        drive(4'd6, 64'd3, 11'd1, 1'b0, 64'd4, 11'd0, 1'b0, 1'b0, 4'd1);
        @(posedge clk);
        @(negedge clk);
        drive(4'd0, 64'd10, 11'd0, 1'b0, 64'd20, 11'd0, 1'b0, 1'b0, 4'd2);
        #1 check(in_ready == 1'b1, "R7", "ready for overlapping fast", 64'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_tag == 4'd2, "R7", "fast overtakes slow", 64'(out_tag), 2);
        check(out_result == 64'd30, "R7", "fast result", out_result, 30);
        drive(4'd1, 64'd50, 11'd0, 1'b0, 64'd8, 11'd0, 1'b0, 1'b0, 4'd3);
        #1 check(in_ready == 1'b0, "R7", "stall on collision", 64'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_tag == 4'd1, "R7", "slow completes", 64'(out_tag), 1);
        check(out_result == 64'd64, "R7", "slow result", out_result, 64);
        #1 check(in_ready == 1'b1, "R7", "stall released", 64'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_tag == 4'd3, "R7", "stalled op completes", 64'(out_tag), 3);
        check(out_result == 64'd42, "R7", "stalled op result", out_result, 42);
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "single pulse", 64'(out_valid), 0);

        // R7: three slow ops back to back never stall
        for (int k = 0; k < 3; k++) begin
            drive(4'd7, 64'h100, 11'd0, 1'b0, 64'(k), 11'd1, 1'b0, 1'b0, 4'(4 + k));
            #1 check(in_ready == 1'b1, "R7", "slow never stalls", 64'(in_ready), 1);
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(out_valid && out_tag == 4'(4 + k), "R7", "slow stream tag",
                  64'(out_tag), 64'(4 + k));
            check(out_result == (64'h100 >> (k + 1)), "R7", "slow stream result",
                  out_result, 64'h100 >> (k + 1));
            @(negedge clk);
        end
        check(out_valid == 1'b0, "R8", "stream drained", 64'(out_valid), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule